// File: doc/BRIEF.md
# Trace Packet Encapsulator with Periodic Synchronization

This block takes complete trace payloads from a producer and turns each one into an encapsulated packet, delivered one byte per transfer on a valid/ready output stream. A payload arrives in parallel with a byte count, a packet-kind code and a timestamp sample. The block writes a one-byte header, then an optional packed prefix (source identifier and kind field), then an optional timestamp, then the payload bytes.

Which optional fields appear is set by static configuration inputs. These inputs are source-identifier suppression, identifier width and value, timestamp enable and width, kind-field width, a flow code copied into the header, and a sync-interval exponent. The output byte count is tracked. Once the count reaches the interval, the block places a run of zero bytes at the next packet boundary. A receiver uses this run to find packet alignment again.

Top module: `trace_encap`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: The first byte of each packet is the header. Bit 7 is the extend flag. Bits [6:5] carry `cfg_flow`. Bits [4:0] count the bytes after the header, leaving out the timestamp bytes (prefix bytes plus payload bytes).
- R3: The source identifier appears only when `cfg_src_inhibit` is 0. It is then the low `cfg_src_bits` bits of `cfg_src_id` (0 to 8), placed from bit 0 of the first prefix byte. When `cfg_src_inhibit` is 1, it adds no bits.
- R4: A timestamp is attached only when `cfg_ts_enable` is 1 and `cfg_ts_width` is non-zero. It then takes ceil(width/8) bytes, least significant byte first, and bits at or above the width are zero. The extend flag is 1 exactly when a timestamp is attached.
- R5: The kind field follows the identifier bits directly. Width 0 omits it. Width 1 sends `in_kind[0]`, with 0 for instruction trace and 1 for data trace. Width 2 sends `in_kind[1:0]` unchanged.
- R6: Identifier and kind bits are padded with zero bits to ceil((id bits + kind bits)/8) prefix bytes. When there are no such bits, no prefix byte is sent.
- R7: The payload has 1 to 16 bytes, given by `in_len`. Bytes go out in order, starting with `in_data[7:0]`.
- R8: Once at least 2^(`cfg_sync_freq`+4) packet bytes have been sent since reset or since the last sync, exactly 32 zero bytes are sent before the next packet and never inside one. Sync bytes are not counted.
- R9: `in_ready` is 1 only while no packet or sync is being sent and no sync is pending. While `out_valid` is 1 and `out_ready` is 0, `out_byte` and `out_valid` stay unchanged.
- R10: Each packet goes out in this order: header, prefix, timestamp, payload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_src_inhibit | input | 1 | 1 suppresses the source identifier |
| cfg_src_bits | input | 4 | Source identifier width in bits (0..8) |
| cfg_src_id | input | 8 | Source identifier value |
| cfg_ts_enable | input | 1 | Timestamp enable |
| cfg_ts_width | input | 6 | Timestamp width in bits (0..32) |
| cfg_type_width | input | 2 | Kind field width (0..2) |
| cfg_flow | input | 2 | Flow code copied into header bits [6:5] |
| cfg_sync_freq | input | 4 | Sync interval exponent; interval is 2^(value+4) bytes |
| in_valid | input | 1 | Payload offered |
| in_ready | output | 1 | Payload accepted on this cycle if offered |
| in_kind | input | 2 | Packet kind code |
| in_len | input | 5 | Payload byte count (1..16) |
| in_data | input | 128 | Payload bytes, byte 0 in bits [7:0] |
| in_ts | input | 32 | Timestamp sample |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Consumer accepts output byte |
| out_byte | output | 8 | Output byte |

## Verification
The assertions assume three things about the inputs. `in_len` lies between 1 and 16. The configuration inputs change only while the block is idle with no sync pending. `cfg_src_bits` and `cfg_type_width` stay within their stated ranges. The stimulus respects all three. It resets the block before each configuration group, so no group starts with a partly counted sync interval. It changes configuration only between packets, after the previous packet has fully drained. It chooses lengths and widths from the legal ranges only, so the stall, accept and header properties are always checked against legal traffic.

// File: rtl/trace_encap_pkg.sv
// Package: shared types and helpers for the trace encapsulator.
// Assumes: nothing beyond IEEE 1800-2017.
package trace_encap_pkg;

    // Sequencer phases, in the order a packet leaves the block.
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_SYNC = 3'd1,
        ST_HDR  = 3'd2,
        ST_PRE  = 3'd3,
        ST_TS   = 3'd4,
        ST_PAY  = 3'd5
    } seq_state_e;

    // Header length field width; fixed by the one-byte header layout.
    localparam int HDR_LEN_W = 5;

    // Whole bytes needed to hold a bit count.
    function automatic int bytes_for_bits(input int nbits);
        return (nbits + 7) / 8;
    endfunction

endpackage

// File: rtl/encap_fields.sv
// Module: encap_fields
// Builds the header byte, the packed prefix (source id then kind bits,
// LSB first, zero padded), the masked timestamp and the field byte counts
// from the live configuration and the offered payload. Purely combinational.
// Assumes: in_len + prefix bytes fits the 5-bit header length field.
module encap_fields
    import trace_encap_pkg::*;
#(
    parameter int SRC_W_MAX  = 8,
    parameter int TS_W_MAX   = 32,
    parameter int TYPE_W_MAX = 2,
    localparam int SRCB_W    = $clog2(SRC_W_MAX + 1),
    localparam int TSB_W     = $clog2(TS_W_MAX + 1),
    localparam int TYB_W     = $clog2(TYPE_W_MAX + 1),
    localparam int PRE_BYTES = bytes_for_bits(SRC_W_MAX + TYPE_W_MAX),
    localparam int PRE_W     = PRE_BYTES * 8,
    localparam int TS_BYTES  = bytes_for_bits(TS_W_MAX),
    localparam int PN_W      = $clog2(PRE_BYTES + 1),
    localparam int TN_W      = $clog2(TS_BYTES + 1)
) (
    input  logic                  cfg_src_inhibit,
    input  logic [SRCB_W-1:0]     cfg_src_bits,
    input  logic [SRC_W_MAX-1:0]  cfg_src_id,
    input  logic                  cfg_ts_enable,
    input  logic [TSB_W-1:0]      cfg_ts_width,
    input  logic [TYB_W-1:0]      cfg_type_width,
    input  logic [1:0]            cfg_flow,
    input  logic [TYPE_W_MAX-1:0] in_kind,
    input  logic [HDR_LEN_W-1:0]  in_len,
    input  logic [TS_W_MAX-1:0]   in_ts,
    output logic [7:0]            hdr_byte,
    output logic [PRE_W-1:0]      pre_bits,
    output logic [PN_W-1:0]       pre_n,
    output logic [TS_W_MAX-1:0]   ts_masked,
    output logic [TN_W-1:0]       ts_n
);

    int                    src_eff;
    int                    typ_eff;
    int                    ts_eff;
    logic                  ts_on;
    logic [PRE_W-1:0]      src_part;
    logic [PRE_W-1:0]      kind_part;

    // Clamp the configured widths to what the hardware was sized for.
    always_comb begin
        src_eff = cfg_src_inhibit ? 0 : int'(cfg_src_bits);
        if (src_eff > SRC_W_MAX) src_eff = SRC_W_MAX;
        typ_eff = int'(cfg_type_width);
        if (typ_eff > TYPE_W_MAX) typ_eff = TYPE_W_MAX;
        ts_eff = int'(cfg_ts_width);
        if (ts_eff > TS_W_MAX) ts_eff = TS_W_MAX;
    end

    // Mask the source id and kind to their active widths.
    always_comb begin
        src_part  = '0;
        kind_part = '0;
        for (int i = 0; i < SRC_W_MAX; i++) begin
            if (i < src_eff) src_part[i] = cfg_src_id[i];
        end
        for (int k = 0; k < TYPE_W_MAX; k++) begin
            if (k < typ_eff) kind_part[k] = in_kind[k];
        end
    end

    // Pack kind bits immediately above the source id bits.
    always_comb begin
        pre_bits = src_part | (kind_part << src_eff);
        pre_n    = PN_W'(bytes_for_bits(src_eff + typ_eff));
    end

    // Timestamp presence, byte count and masking.
    always_comb begin
        ts_on     = cfg_ts_enable && (ts_eff != 0);
        ts_n      = ts_on ? TN_W'(bytes_for_bits(ts_eff)) : '0;
        ts_masked = '0;
        for (int b = 0; b < TS_W_MAX; b++) begin
            if (b < ts_eff) ts_masked[b] = in_ts[b];
        end
    end

    // Header: extend flag, flow code, bytes after header excluding timestamp.
    always_comb begin
        hdr_byte = {ts_on, cfg_flow, HDR_LEN_W'(int'(pre_n) + int'(in_len))};
    end

endmodule

// File: rtl/sync_timer.sv
// Module: sync_timer
// Counts packet bytes leaving the block and raises sync_pending once the
// count reaches 2^(cfg_sync_freq+4). Clears when a sync run completes.
// Assumes: cfg_sync_freq is static while traffic flows.
module sync_timer #(
    parameter int FREQ_W = 4,
    localparam int CNT_W = (1 << FREQ_W) + 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FREQ_W-1:0] cfg_sync_freq,
    input  logic              byte_fire,
    input  logic              sync_done,
    output logic              sync_pending
);

    logic [CNT_W-1:0] byte_cnt;
    logic [CNT_W-1:0] interval;

    // Interval in bytes derived from the exponent.
    always_comb begin
        interval = CNT_W'(1) << (int'(cfg_sync_freq) + 4);
    end

    // Saturating packet-byte counter, cleared at the end of each sync run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_cnt <= '0;
        end else if (sync_done) begin
            byte_cnt <= '0;
        end else if (byte_fire && (byte_cnt != {CNT_W{1'b1}})) begin
            byte_cnt <= byte_cnt + CNT_W'(1);
        end
    end

    // Pending once the interval has elapsed.
    always_comb begin
        sync_pending = (byte_cnt >= interval);
    end

endmodule

// File: rtl/byte_sequencer.sv
// Module: byte_sequencer
// Captures an accepted packet's fields and shifts them out one byte per
// output transfer: header, prefix, timestamp, payload. In idle with a sync
// pending it sends a run of 2^HDR_LEN_W zero bytes before anything else.
// Assumes: in_len is 1..MAX_PAYLOAD; a stalled output holds all state.
module byte_sequencer
    import trace_encap_pkg::*;
#(
    parameter int MAX_PAYLOAD = 16,
    parameter int PRE_W       = 16,
    parameter int PN_W        = 2,
    parameter int TS_W_MAX    = 32,
    parameter int TN_W        = 3,
    localparam int PAY_W      = MAX_PAYLOAD * 8,
    localparam int IDX_W      = HDR_LEN_W,
    localparam int SYNC_LEN   = 1 << HDR_LEN_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sync_pending,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [HDR_LEN_W-1:0] in_len,
    input  logic [PAY_W-1:0]     in_data,
    input  logic [7:0]           hdr_byte,
    input  logic [PRE_W-1:0]     pre_bits,
    input  logic [PN_W-1:0]      pre_n,
    input  logic [TS_W_MAX-1:0]  ts_masked,
    input  logic [TN_W-1:0]      ts_n,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [7:0]           out_byte,
    output logic                 byte_fire,
    output logic                 sync_done
);

    seq_state_e              state;
    logic [IDX_W-1:0]        idx;
    logic [7:0]              hdr_q;
    logic [PRE_W-1:0]        pre_sr;
    logic [PN_W-1:0]         pre_n_q;
    logic [TS_W_MAX-1:0]     ts_sr;
    logic [TN_W-1:0]         ts_n_q;
    logic [PAY_W-1:0]        pay_sr;
    logic [HDR_LEN_W-1:0]    len_q;
    logic                    fire;
    logic                    last_pre;
    logic                    last_ts;
    logic                    last_pay;
    logic                    last_sync;
    seq_state_e              after_hdr;
    seq_state_e              after_pre;

    // Handshake and end-of-field decodes.
    always_comb begin
        fire      = out_valid && out_ready;
        in_ready  = (state == ST_IDLE) && !sync_pending;
        last_sync = (idx == IDX_W'(SYNC_LEN - 1));
        last_pre  = (idx == IDX_W'(pre_n_q) - IDX_W'(1));
        last_ts   = (idx == IDX_W'(ts_n_q) - IDX_W'(1));
        last_pay  = (idx == IDX_W'(len_q) - IDX_W'(1));
        byte_fire = fire && (state != ST_SYNC);
        sync_done = fire && (state == ST_SYNC) && last_sync;
    end

    // Next field after the header and after the prefix, skipping empty ones.
    always_comb begin
        if (ts_n_q != '0) after_pre = ST_TS;
        else              after_pre = ST_PAY;
        if (pre_n_q != '0) after_hdr = ST_PRE;
        else               after_hdr = after_pre;
    end

    // Output byte selection by phase.
    always_comb begin
        out_valid = (state != ST_IDLE);
        case (state)
            ST_HDR:  out_byte = hdr_q;
            ST_PRE:  out_byte = pre_sr[7:0];
            ST_TS:   out_byte = ts_sr[7:0];
            ST_PAY:  out_byte = pay_sr[7:0];
            default: out_byte = 8'h00;
        endcase
    end

    // Phase machine with field capture and byte shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            idx     <= '0;
            hdr_q   <= '0;
            pre_sr  <= '0;
            pre_n_q <= '0;
            ts_sr   <= '0;
            ts_n_q  <= '0;
            pay_sr  <= '0;
            len_q   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    idx <= '0;
                    if (sync_pending) begin
                        state <= ST_SYNC;
                    end else if (in_valid) begin
                        state   <= ST_HDR;
                        hdr_q   <= hdr_byte;
                        pre_sr  <= pre_bits;
                        pre_n_q <= pre_n;
                        ts_sr   <= ts_masked;
                        ts_n_q  <= ts_n;
                        pay_sr  <= in_data;
                        len_q   <= in_len;
                    end
                end
                ST_SYNC: begin
                    if (fire) begin
                        if (last_sync) begin
                            state <= ST_IDLE;
                            idx   <= '0;
                        end else begin
                            idx <= idx + IDX_W'(1);
                        end
                    end
                end
                ST_HDR: begin
                    if (fire) begin
                        state <= after_hdr;
                        idx   <= '0;
                    end
                end
                ST_PRE: begin
                    if (fire) begin
                        pre_sr <= pre_sr >> 8;
                        if (last_pre) begin
                            state <= after_pre;
                            idx   <= '0;
                        end else begin
                            idx <= idx + IDX_W'(1);
                        end
                    end
                end
                ST_TS: begin
                    if (fire) begin
                        ts_sr <= ts_sr >> 8;
                        if (last_ts) begin
                            state <= ST_PAY;
                            idx   <= '0;
                        end else begin
                            idx <= idx + IDX_W'(1);
                        end
                    end
                end
                ST_PAY: begin
                    if (fire) begin
                        pay_sr <= pay_sr >> 8;
                        if (last_pay) begin
                            state <= ST_IDLE;
                            idx   <= '0;
                        end else begin
                            idx <= idx + IDX_W'(1);
                        end
                    end
                end
                default: begin
                    state <= ST_IDLE;
                    idx   <= '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/trace_encap.sv
// Module: trace_encap (top)
// Wraps trace payloads into encapsulated byte packets with optional source
// id, timestamp and kind fields, and inserts zero-byte sync runs at packet
// boundaries after a configurable number of output bytes.
// Assumes: configuration is static while packets are in flight; in_len is
// 1..MAX_PAYLOAD and MAX_PAYLOAD plus prefix bytes fits in 5 bits.
module trace_encap
    import trace_encap_pkg::*;
#(
    parameter int MAX_PAYLOAD = 16,
    parameter int SRC_W_MAX   = 8,
    parameter int TS_W_MAX    = 32,
    parameter int TYPE_W_MAX  = 2,
    parameter int FREQ_W      = 4,
    localparam int SRCB_W     = $clog2(SRC_W_MAX + 1),
    localparam int TSB_W      = $clog2(TS_W_MAX + 1),
    localparam int TYB_W      = $clog2(TYPE_W_MAX + 1),
    localparam int PRE_BYTES  = bytes_for_bits(SRC_W_MAX + TYPE_W_MAX),
    localparam int PRE_W      = PRE_BYTES * 8,
    localparam int TS_BYTES   = bytes_for_bits(TS_W_MAX),
    localparam int PN_W       = $clog2(PRE_BYTES + 1),
    localparam int TN_W       = $clog2(TS_BYTES + 1),
    localparam int PAY_W      = MAX_PAYLOAD * 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_src_inhibit,
    input  logic [SRCB_W-1:0]     cfg_src_bits,
    input  logic [SRC_W_MAX-1:0]  cfg_src_id,
    input  logic                  cfg_ts_enable,
    input  logic [TSB_W-1:0]      cfg_ts_width,
    input  logic [TYB_W-1:0]      cfg_type_width,
    input  logic [1:0]            cfg_flow,
    input  logic [FREQ_W-1:0]     cfg_sync_freq,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic [TYPE_W_MAX-1:0] in_kind,
    input  logic [HDR_LEN_W-1:0]  in_len,
    input  logic [PAY_W-1:0]      in_data,
    input  logic [TS_W_MAX-1:0]   in_ts,
    output logic                  out_valid,
    input  logic                  out_ready,
    output logic [7:0]            out_byte
);

    logic [7:0]          hdr_byte;
    logic [PRE_W-1:0]    pre_bits;
    logic [PN_W-1:0]     pre_n;
    logic [TS_W_MAX-1:0] ts_masked;
    logic [TN_W-1:0]     ts_n;
    logic                sync_pending;
    logic                byte_fire;
    logic                sync_done;

    encap_fields #(
        .SRC_W_MAX  (SRC_W_MAX),
        .TS_W_MAX   (TS_W_MAX),
        .TYPE_W_MAX (TYPE_W_MAX)
    ) u_fields (
        .cfg_src_inhibit (cfg_src_inhibit),
        .cfg_src_bits    (cfg_src_bits),
        .cfg_src_id      (cfg_src_id),
        .cfg_ts_enable   (cfg_ts_enable),
        .cfg_ts_width    (cfg_ts_width),
        .cfg_type_width  (cfg_type_width),
        .cfg_flow        (cfg_flow),
        .in_kind         (in_kind),
        .in_len          (in_len),
        .in_ts           (in_ts),
        .hdr_byte        (hdr_byte),
        .pre_bits        (pre_bits),
        .pre_n           (pre_n),
        .ts_masked       (ts_masked),
        .ts_n            (ts_n)
    );

    sync_timer #(
        .FREQ_W (FREQ_W)
    ) u_sync (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_sync_freq (cfg_sync_freq),
        .byte_fire     (byte_fire),
        .sync_done     (sync_done),
        .sync_pending  (sync_pending)
    );

    byte_sequencer #(
        .MAX_PAYLOAD (MAX_PAYLOAD),
        .PRE_W       (PRE_W),
        .PN_W        (PN_W),
        .TS_W_MAX    (TS_W_MAX),
        .TN_W        (TN_W)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .sync_pending (sync_pending),
        .in_valid     (in_valid),
        .in_ready     (in_ready),
        .in_len       (in_len),
        .in_data      (in_data),
        .hdr_byte     (hdr_byte),
        .pre_bits     (pre_bits),
        .pre_n        (pre_n),
        .ts_masked    (ts_masked),
        .ts_n         (ts_n),
        .out_valid    (out_valid),
        .out_ready    (out_ready),
        .out_byte     (out_byte),
        .byte_fire    (byte_fire),
        .sync_done    (sync_done)
    );

endmodule

// File: rtl/trace_encap_chk.sv
// Module: trace_encap_chk
// Port-level protocol checks for trace_encap, attached by bind.
// Assumes: inputs obey the ranges listed in the brief.
module trace_encap_chk #(
    parameter int TSB_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [7:0]       out_byte,
    input logic             cfg_ts_enable,
    input logic [TSB_W-1:0] cfg_ts_width,
    input logic [1:0]       cfg_flow
);

    // R1: the cycle after a reset edge shows no output activity.
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> !out_valid);

    // R9: a stalled byte is held unchanged.
    assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && (out_byte == $past(out_byte))));

    // R9: input is only offered a slot while nothing is being sent.
    assert_ready_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> !out_valid);

    // R4: extend flag of the header follows timestamp attachment.
    assert_hdr_extend_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=>
            (out_valid && (out_byte[7] == $past(cfg_ts_enable && (cfg_ts_width != '0)))));

    // R2: flow code lands in header bits [6:5].
    assert_hdr_flow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (out_byte[6:5] == $past(cfg_flow)));

endmodule

bind trace_encap trace_encap_chk #(.TSB_W(TSB_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_ready      (in_ready),
    .out_valid     (out_valid),
    .out_ready     (out_ready),
    .out_byte      (out_byte),
    .cfg_ts_enable (cfg_ts_enable),
    .cfg_ts_width  (cfg_ts_width),
    .cfg_flow      (cfg_flow)
);

// File: tb/tb_trace_encap.sv
// Bench: sweeps configuration combinations, builds each expected byte
// stream arithmetically and compares it with the captured output stream.
module tb_trace_encap;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_src_inhibit = 1'b0;
    logic [3:0]   cfg_src_bits = '0;
    logic [7:0]   cfg_src_id = '0;
    logic         cfg_ts_enable = 1'b0;
    logic [5:0]   cfg_ts_width = '0;
    logic [1:0]   cfg_type_width = '0;
    logic [1:0]   cfg_flow = '0;
    logic [3:0]   cfg_sync_freq = 4'd15;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [1:0]   in_kind = '0;
    logic [4:0]   in_len = 5'd1;
    logic [127:0] in_data = '0;
    logic [31:0]  in_ts = '0;
    logic         out_valid;
    logic         out_ready = 1'b1;
    logic [7:0]   out_byte;

    int           n_tests = 0;
    int           n_fail = 0;
    int           cycles = 0;
    bit           bp_en = 1'b0;
    logic [15:0]  lfsr = 16'hACE1;
    logic [7:0]   got_q[$];
    logic [7:0]   exp_q[$];
    int           model_cnt = 0;
    bit           stall_seen = 1'b0;
    logic [7:0]   stall_byte = '0;

    always #4 clk = ~clk;

    trace_encap dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .cfg_src_inhibit (cfg_src_inhibit),
        .cfg_src_bits    (cfg_src_bits),
        .cfg_src_id      (cfg_src_id),
        .cfg_ts_enable   (cfg_ts_enable),
        .cfg_ts_width    (cfg_ts_width),
        .cfg_type_width  (cfg_type_width),
        .cfg_flow        (cfg_flow),
        .cfg_sync_freq   (cfg_sync_freq),
        .in_valid        (in_valid),
        .in_ready        (in_ready),
        .in_kind         (in_kind),
        .in_len          (in_len),
        .in_data         (in_data),
        .in_ts           (in_ts),
        .out_valid       (out_valid),
        .out_ready       (out_ready),
        .out_byte        (out_byte)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // Watchdog: an overlong run counts as one failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            check(1'b0, "watchdog", cycles, 150000);
            finish_run();
        end
    end

    // Backpressure pattern driver.
    always @(negedge clk) begin
        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        out_ready <= bp_en ? lfsr[0] : 1'b1;
    end

    // Monitor between edges: capture transfers, check stalls and ready (R9).
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            if (stall_seen) begin
                check(out_valid && (out_byte == stall_byte), "R9 stall hold",
                      {out_valid, out_byte}, {1'b1, stall_byte});
            end
            stall_seen = out_valid && !out_ready;
            stall_byte = out_byte;
            if (out_valid && in_ready) check(1'b0, "R9 ready while busy", 1, 0);
            if (out_valid && out_ready) got_q.push_back(out_byte);
        end else begin
            stall_seen = 1'b0;
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        got_q.delete();
        exp_q.delete();
        model_cnt = 0;
        #2;
        check(!out_valid, "R1 out_valid after reset", out_valid, 0);
        check(in_ready, "R1 in_ready after reset", in_ready, 1);
    endtask

    // Expected bytes for one packet, including any sync run before it (R8).
    task automatic model_pkt(input logic [1:0] kind, input int len,
                             input logic [127:0] data, input logic [31:0] ts);
        int s, t, pn, tn, w;
        logic [63:0] bits, tsm;
        if (model_cnt >= (1 << (cfg_sync_freq + 4))) begin
            for (int z = 0; z < 32; z++) exp_q.push_back(8'h00);
            model_cnt = 0;
        end
        s = cfg_src_inhibit ? 0 : int'(cfg_src_bits);
        t = int'(cfg_type_width);
        bits = (64'(cfg_src_id) & ((64'd1 << s) - 1)) |
               ((64'(kind) & ((64'd1 << t) - 1)) << s);
        pn = (s + t + 7) / 8;
        w  = int'(cfg_ts_width);
        tn = (cfg_ts_enable && w != 0) ? (w + 7) / 8 : 0;
        tsm = 64'(ts) & ((64'd1 << w) - 1);
        exp_q.push_back({(tn != 0) ? 1'b1 : 1'b0, cfg_flow, 5'(pn + len)});
        for (int i = 0; i < pn; i++) exp_q.push_back(bits[i*8 +: 8]);
        for (int i = 0; i < tn; i++) exp_q.push_back(tsm[i*8 +: 8]);
        for (int i = 0; i < len; i++) exp_q.push_back(data[i*8 +: 8]);
        model_cnt += 1 + pn + tn + len;
    endtask

    // Wait for the output stream to reach the expected length, then compare.
    task automatic compare_stream(input string req);
        int guard = 0;
        int bad = -1;
        while (got_q.size() < exp_q.size() && guard < 3000) begin
            @(negedge clk);
            guard++;
        end
        #2;
        for (int i = 0; i < exp_q.size(); i++) begin
            if (bad < 0 && (i >= got_q.size() || got_q[i] !== exp_q[i])) bad = i;
        end
        if (bad < 0) check(1'b1, req, 0, 0);
        else check(1'b0, req, (bad < got_q.size()) ? got_q[bad] : -1, exp_q[bad]);
    endtask

    task automatic send(input logic [1:0] kind, input int len,
                        input logic [127:0] data, input logic [31:0] ts, input string req);
        model_pkt(kind, len, data, ts);
        @(negedge clk);
        in_valid = 1'b1;
        in_kind  = kind;
        in_len   = 5'(len);
        in_data  = data;
        in_ts    = ts;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        in_valid = 1'b0;
        compare_stream(req);
    endtask

    function automatic logic [127:0] pattern(input int seed);
        logic [127:0] p;
        for (int i = 0; i < 16; i++) p[i*8 +: 8] = 8'((seed * 37 + i * 11 + 5) & 255);
        return p;
    endfunction

    initial begin
        do_reset();

        // R3 R5 R6 R10: identifier and kind packing sweep, no timestamp.
        for (int inh = 0; inh < 2; inh++) begin
            for (int sb = 0; sb < 3; sb++) begin
                for (int tw = 0; tw < 3; tw++) begin
                    for (int kd = 0; kd < 4; kd++) begin
                        cfg_src_inhibit = 1'(inh);
                        cfg_src_bits    = (sb == 0) ? 4'd0 : (sb == 1) ? 4'd3 : 4'd8;
                        cfg_src_id      = 8'hA5 ^ 8'(kd * 16);
                        cfg_type_width  = 2'(tw);
                        send(2'(kd), 1 + ((sb * 4 + kd) % 5), pattern(kd + sb),
                             32'h0, "R3 R5 R6 R10 prefix packing");
                    end
                end
            end
        end

        // R2 R4: timestamp width, enable and flow code sweep.
        do_reset();
        cfg_src_inhibit = 1'b0;
        cfg_src_bits    = 4'd5;
        cfg_type_width  = 2'd1;
        for (int en = 0; en < 2; en++) begin
            for (int wi = 0; wi < 9; wi++) begin
                for (int fl = 0; fl < 4; fl++) begin
                    int widths[9] = '{0, 1, 7, 8, 9, 16, 24, 31, 32};
                    cfg_ts_enable = 1'(en);
                    cfg_ts_width  = 6'(widths[wi]);
                    cfg_flow      = 2'(fl);
                    send(2'(fl & 1), 3, pattern(wi), 32'hFEDC_BA98 ^ 32'(wi * 977),
                         "R2 R4 header and timestamp");
                end
            end
        end

        // R7: every payload length, with backpressure (R9).
        do_reset();
        cfg_ts_enable = 1'b1;
        cfg_ts_width  = 6'd12;
        cfg_flow      = 2'd2;
        bp_en = 1'b1;
        for (int ln = 1; ln <= 16; ln++) begin
            send(2'd1, ln, pattern(ln * 3), 32'(ln * 4099), "R7 payload length");
        end

        // R8: sync insertion at the two shortest intervals, with backpressure.
        for (int fq = 0; fq < 2; fq++) begin
            do_reset();
            cfg_sync_freq = 4'(fq);
            for (int p = 0; p < 20; p++) begin
                send(2'(p & 3), 1 + (p * 7) % 16, pattern(p), 32'(p * 31),
                     "R8 sync insertion");
            end
            if (model_cnt >= (1 << (fq + 4))) begin
                for (int z = 0; z < 32; z++) exp_q.push_back(8'h00);
                model_cnt = 0;
            end
            compare_stream("R8 trailing sync");
            repeat (40) @(negedge clk);
            #2;
            check(got_q.size() == exp_q.size(), "R8 no extra bytes", got_q.size(), exp_q.size());
        end
        bp_en = 1'b0;
        cfg_sync_freq = 4'd15;

        finish_run();
    end

endmodule